// File: doc/BRIEF.md
# Cumulative Benefit Coprocessor Manager

This block makes an online choice, one application instance at a time, about which reconfigurable coprocessors should occupy a fixed number of fabric slots. For each application it holds a software-only runtime, a runtime with its coprocessor, and a running benefit score. Each arriving instance first decays every score by a fade factor and then adds the arriving application's per-instance saving to its own score. The block then reports one of three decisions: the coprocessor is already resident, a load into a given slot (possibly displacing a victim), or run in software.

Loading follows a rent-or-buy rule. A coprocessor is fetched only after its accumulated saving is strictly greater than the reconfiguration cost. When every slot is occupied, a linear scan visits one slot per cycle to find the resident with the lowest score. The candidate replaces that resident only if its score minus the reconfiguration cost is strictly greater than the victim's score. The bitstream transfer itself is left to the surrounding system, which acts on the decision that `done` qualifies.

The controller is a five-state machine:
- ST_IDLE waits for a request and moves to ST_UPDATE when one is accepted.
- ST_UPDATE fades and accumulates the scores, then always moves to ST_CHECK.
- ST_CHECK moves to ST_DONE when the application is resident, below threshold, or has a free slot. Otherwise it moves to ST_SCAN.
- ST_SCAN steps through the slots and moves to ST_DONE after the last one.
- ST_DONE raises `done` for one cycle and returns to ST_IDLE.

Top module: `cbm_manager`

## Requirements
- R1: After reset `done` is low, every score is zero and every slot is empty, so the first load goes to slot 0 without eviction.
- R2: The per-instance saving is the software runtime minus the coprocessor runtime, or 0 when the coprocessor runtime is not smaller. It is added to the arriving application's score after the fade step. A table write for an application clears its score.
- R3: A non-resident application is considered for loading only when its score is strictly greater than `load_time`. At equality or below, the decision is software (code 2).
- R4: A load candidate that finds an empty slot gets decision load (code 1) into the lowest-numbered empty slot, with `evict` low.
- R5: With all slots full, the victim is the resident with the lowest score, and the lower slot number wins a tie. The candidate loads into the victim's slot with `evict` high and `victim_app` naming the displaced application only if the candidate's score minus `load_time` is strictly greater than the victim's score. Otherwise the decision is software.
- R6: An instance whose coprocessor is resident gets decision resident (code 0) with `evict` low, and the slot contents do not change.
- R7: On every accepted instance, each score becomes floor(score × f / 256), where f is `fade` with any value above 256 treated as 256.
- R8: `done` is a one-cycle pulse that rises 2 clock edges after the edge that accepts the request. When the eviction scan runs, it rises NUM_SLOTS edges later than that.
- R9: `req_valid` outside ST_IDLE is ignored: it produces no decision and does not change any score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one application's runtimes and clear its score |
| cfg_app | input | APP_W | Application written by `cfg_we` |
| cfg_sw_time | input | TIME_W | Software-only runtime |
| cfg_hw_time | input | TIME_W | Runtime with the coprocessor |
| load_time | input | TIME_W | Reconfiguration cost in runtime units |
| fade | input | FRAC_W+1 | Fade factor, unsigned with FRAC_W fraction bits |
| req_valid | input | 1 | An application instance arrives (taken in ST_IDLE) |
| req_app | input | APP_W | Arriving application |
| done | output | 1 | Decision outputs are valid this cycle |
| decision | output | 2 | 0 resident, 1 load, 2 software |
| slot | output | SLOT_W | Slot to load when decision is load |
| evict | output | 1 | The load displaces a resident coprocessor |
| victim_app | output | APP_W | Displaced application when `evict` is high |

## Verification
The bench builds the block with four applications and two slots. With only two slots, eviction and refusal are reached after a handful of arrivals, and the tie between equal scores in both slots can be set up directly. Fade is driven across half, unity and above-unity values, so decay, truncation and clamping all feed later decisions. Load times range from zero to above any single saving, which exercises the strict threshold at equality.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [1:0] {
        DEC_RESIDENT = 2'd0,
        DEC_LOAD     = 2'd1,
        DEC_SOFTWARE = 2'd2
    } cbm_dec_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UPDATE,
        ST_CHECK,
        ST_SCAN,
        ST_DONE
    } cbm_state_e;
endpackage

// File: rtl/cbm_benefit_bank.sv
module cbm_benefit_bank #(
    parameter int NUM_APPS = 8,
    parameter int APP_W    = 3,
    parameter int TIME_W   = 16,
    parameter int CB_W     = 24,
    parameter int FRAC_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [APP_W-1:0]               cfg_app,
    input  logic [TIME_W-1:0]              cfg_sw,
    input  logic [TIME_W-1:0]              cfg_hw,
    input  logic                           upd,
    input  logic [APP_W-1:0]               upd_app,
    input  logic [FRAC_W:0]                fade_q,
    output logic [NUM_APPS-1:0][CB_W-1:0]  cb_o
);
    for (genvar g = 0; g < NUM_APPS; g++) begin : g_app
        logic [TIME_W-1:0]      sw_r, hw_r, gain;
        logic [CB_W-1:0]        cb_r, faded, next_cb;
        logic [CB_W+FRAC_W:0]   prod;
        logic [CB_W:0]          sum;

        assign gain    = (sw_r > hw_r) ? (sw_r - hw_r) : '0;
        assign prod    = cb_r * fade_q;
        assign faded   = CB_W'(prod >> FRAC_W);
        assign sum     = {1'b0, faded} +
                         ((upd_app == APP_W'(g)) ? (CB_W+1)'(gain) : '0);
        assign next_cb = sum[CB_W] ? '1 : sum[CB_W-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_r <= '0;
                hw_r <= '0;
                cb_r <= '0;
            end else if (cfg_we && cfg_app == APP_W'(g)) begin
                sw_r <= cfg_sw;
                hw_r <= cfg_hw;
                cb_r <= '0;
            end else if (upd) begin
                cb_r <= next_cb;
            end
        end

        assign cb_o[g] = cb_r;
    end
endmodule

// File: rtl/cbm_slot_table.sv
module cbm_slot_table #(
    parameter int NUM_SLOTS = 4,
    parameter int APP_W     = 3,
    parameter int SLOT_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SLOT_W-1:0]                wr_slot,
    input  logic [APP_W-1:0]                 wr_app,
    input  logic [APP_W-1:0]                 qry_app,
    output logic                             hit,
    output logic                             free_any,
    output logic [SLOT_W-1:0]                free_slot,
    output logic [NUM_SLOTS-1:0]             valid_o,
    output logic [NUM_SLOTS-1:0][APP_W-1:0]  app_o
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[s] <= 1'b0;
                app_o[s]   <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(s)) begin
                valid_o[s] <= 1'b1;
                app_o[s]   <= wr_app;
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (valid_o[s] && app_o[s] == qry_app) hit = 1'b1;
        end
    end

    always_comb begin
        free_any  = 1'b0;
        free_slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (!valid_o[s]) begin
                free_any  = 1'b1;
                free_slot = SLOT_W'(s);
            end
        end
    end
endmodule

// File: rtl/cbm_manager.sv
module cbm_manager
    import cbm_pkg::*;
#(
    parameter int NUM_APPS  = 8,
    parameter int NUM_SLOTS = 4,
    parameter int TIME_W    = 16,
    parameter int CB_W      = 24,
    parameter int FRAC_W    = 8,
    parameter int APP_W     = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [APP_W-1:0]     cfg_app,
    input  logic [TIME_W-1:0]    cfg_sw_time,
    input  logic [TIME_W-1:0]    cfg_hw_time,
    input  logic [TIME_W-1:0]    load_time,
    input  logic [FRAC_W:0]      fade,
    input  logic                 req_valid,
    input  logic [APP_W-1:0]     req_app,
    output logic                 done,
    output logic [1:0]           decision,
    output logic [SLOT_W-1:0]    slot,
    output logic                 evict,
    output logic [APP_W-1:0]     victim_app
);
    localparam logic [FRAC_W:0] UNITY = (FRAC_W+1)'(1) << FRAC_W;

    cbm_state_e state, nxt;
    cbm_dec_e   dec_q;

    logic [APP_W-1:0]                cur_app;
    logic [FRAC_W:0]                 fade_q;
    logic [NUM_APPS-1:0][CB_W-1:0]   cb_all;
    logic [NUM_SLOTS-1:0]            slot_valid;
    logic [NUM_SLOTS-1:0][APP_W-1:0] slot_app;
    logic                            hit, free_any, wr_en;
    logic [SLOT_W-1:0]               free_slot, wr_slot, scan_idx, min_slot, fin_slot;
    logic [CB_W-1:0]                 cb_cur, lt_ext, cand_net, scan_cb, min_cb, fin_min;
    logic                            over, lower, last, win, in_idle;

    assign fade_q   = (fade > UNITY) ? UNITY : fade;
    assign cb_cur   = cb_all[cur_app];
    assign lt_ext   = CB_W'(load_time);
    assign over     = cb_cur > lt_ext;
    assign cand_net = cb_cur - lt_ext;
    assign scan_cb  = cb_all[slot_app[scan_idx]];
    assign lower    = (scan_idx == '0) || (scan_cb < min_cb);
    assign fin_min  = lower ? scan_cb : min_cb;
    assign fin_slot = lower ? scan_idx : min_slot;
    assign last     = scan_idx == SLOT_W'(NUM_SLOTS - 1);
    assign win      = cand_net > fin_min;
    assign in_idle  = state == ST_IDLE;

    assign wr_en   = (state == ST_CHECK && !hit && over && free_any) ||
                     (state == ST_SCAN && last && win);
    assign wr_slot = (state == ST_SCAN) ? fin_slot : free_slot;

    cbm_benefit_bank #(
        .NUM_APPS(NUM_APPS), .APP_W(APP_W), .TIME_W(TIME_W),
        .CB_W(CB_W), .FRAC_W(FRAC_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_app(cfg_app),
        .cfg_sw(cfg_sw_time), .cfg_hw(cfg_hw_time),
        .upd(state == ST_UPDATE), .upd_app(cur_app),
        .fade_q(fade_q), .cb_o(cb_all)
    );

    cbm_slot_table #(
        .NUM_SLOTS(NUM_SLOTS), .APP_W(APP_W), .SLOT_W(SLOT_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_app(cur_app),
        .qry_app(cur_app), .hit(hit),
        .free_any(free_any), .free_slot(free_slot),
        .valid_o(slot_valid), .app_o(slot_app)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_UPDATE;
            ST_UPDATE: nxt = ST_CHECK;
            ST_CHECK:  nxt = (hit || !over || free_any) ? ST_DONE : ST_SCAN;
            ST_SCAN:   if (last) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_app    <= '0;
            dec_q      <= DEC_SOFTWARE;
            slot       <= '0;
            evict      <= 1'b0;
            victim_app <= '0;
            scan_idx   <= '0;
            min_cb     <= '0;
            min_slot   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) cur_app <= req_app;
                ST_CHECK: begin
                    scan_idx <= '0;
                    evict    <= 1'b0;
                    if (hit) begin
                        dec_q <= DEC_RESIDENT;
                    end else if (!over) begin
                        dec_q <= DEC_SOFTWARE;
                    end else if (free_any) begin
                        dec_q <= DEC_LOAD;
                        slot  <= free_slot;
                    end
                end
                ST_SCAN: begin
                    scan_idx <= scan_idx + SLOT_W'(1);
                    min_cb   <= fin_min;
                    min_slot <= fin_slot;
                    if (last) begin
                        if (win) begin
                            dec_q      <= DEC_LOAD;
                            slot       <= fin_slot;
                            evict      <= 1'b1;
                            victim_app <= slot_app[fin_slot];
                        end else begin
                            dec_q <= DEC_SOFTWARE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign done     = state == ST_DONE;
    assign decision = dec_q;
endmodule

// File: rtl/cbm_manager_chk.sv
module cbm_manager_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int APP_W     = 3,
    parameter int SLOT_W    = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_idle,
    input logic                             req_valid,
    input logic                             done,
    input logic [1:0]                       decision,
    input logic                             evict,
    input logic [SLOT_W-1:0]                slot,
    input logic [APP_W-1:0]                 cur_app,
    input logic [NUM_SLOTS-1:0]             slot_valid,
    input logic [NUM_SLOTS-1:0][APP_W-1:0]  slot_app
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && req_valid) |=> (!done && !in_idle));

    // R5
    evict_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && evict) |-> decision == 2'd1);

    // R4
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && decision == 2'd1) |-> (slot_valid[slot] && slot_app[slot] == cur_app));

    // R6
    resident_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && decision == 2'd0) |-> (!evict && $stable(slot_valid) && $stable(slot_app)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_idle && req_valid) |=> $stable(cur_app));

    // R3
    decision_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> decision != 2'd3);
endmodule

bind cbm_manager cbm_manager_chk #(
    .NUM_SLOTS(NUM_SLOTS), .APP_W(APP_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .req_valid(req_valid),
    .done(done), .decision(decision), .evict(evict), .slot(slot),
    .cur_app(cur_app), .slot_valid(slot_valid), .slot_app(slot_app)
);

// File: tb/cbm_manager_tb.sv
module cbm_manager_tb;
    localparam int NA  = 4;
    localparam int NS  = 2;
    localparam int TW  = 16;
    localparam int CBW = 24;
    localparam int FW  = 8;
    localparam int AW  = 2;
    localparam int SW  = 1;
    localparam longint CBMAX = (64'd1 << CBW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_app = '0;
    logic [TW-1:0] cfg_sw_time = '0, cfg_hw_time = '0, load_time = '0;
    logic [FW:0] fade = 9'd256;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_app = '0;
    logic done, evict;
    logic [1:0] decision;
    logic [SW-1:0] slot;
    logic [AW-1:0] victim_app;

    always #2 clk = ~clk;

    cbm_manager #(
        .NUM_APPS(NA), .NUM_SLOTS(NS), .TIME_W(TW), .CB_W(CBW), .FRAC_W(FW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_app(cfg_app),
        .cfg_sw_time(cfg_sw_time), .cfg_hw_time(cfg_hw_time),
        .load_time(load_time), .fade(fade), .req_valid(req_valid),
        .req_app(req_app), .done(done), .decision(decision), .slot(slot),
        .evict(evict), .victim_app(victim_app)
    );

    int checks = 0;
    int errors = 0;
    longint m_sw[NA], m_hw[NA], m_cb[NA];
    bit     m_sv[NS];
    int     m_sa[NS];
    longint m_lt, m_fade;
    int g_dec, g_lat, g_vic, g_slot;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int a = 0; a < NA; a++) begin m_sw[a] = 0; m_hw[a] = 0; m_cb[a] = 0; end
        for (int s = 0; s < NS; s++) begin m_sv[s] = 0; m_sa[s] = 0; end
    endtask

    task automatic cfg(input int app, input int sw, input int hw);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_app = AW'(app);
        cfg_sw_time = TW'(sw); cfg_hw_time = TW'(hw);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_sw[app] = sw; m_hw[app] = hw; m_cb[app] = 0;
    endtask

    task automatic knobs(input int lt, input int f);
        load_time = TW'(lt); fade = (FW+1)'(f);
        m_lt = lt; m_fade = f;
    endtask

    // Expected decision from the requirements: fade, accumulate, decide.
    task automatic model_step(input int app, output int e_dec, output int e_slot,
                              output int e_ev, output int e_vic, output int e_lat);
        longint fq, gain, mn, net;
        int ms;
        bit hit, found;
        fq = (m_fade > 256) ? 256 : m_fade;
        for (int a = 0; a < NA; a++) m_cb[a] = (m_cb[a] * fq) >> FW;
        gain = (m_sw[app] > m_hw[app]) ? m_sw[app] - m_hw[app] : 0;
        m_cb[app] = (m_cb[app] + gain > CBMAX) ? CBMAX : m_cb[app] + gain;
        hit = 0;
        for (int s = 0; s < NS; s++) if (m_sv[s] && m_sa[s] == app) hit = 1;
        e_slot = 0; e_ev = 0; e_vic = 0; e_lat = 2;
        if (hit) e_dec = 0;
        else if (m_cb[app] <= m_lt) e_dec = 2;
        else begin
            found = 0;
            for (int s = NS - 1; s >= 0; s--) if (!m_sv[s]) begin found = 1; e_slot = s; end
            if (found) begin
                e_dec = 1;
                m_sv[e_slot] = 1; m_sa[e_slot] = app;
            end else begin
                e_lat = 2 + NS;
                ms = 0; mn = m_cb[m_sa[0]];
                for (int s = 1; s < NS; s++) if (m_cb[m_sa[s]] < mn) begin mn = m_cb[m_sa[s]]; ms = s; end
                net = m_cb[app] - m_lt;
                if (net > mn) begin
                    e_dec = 1; e_slot = ms; e_ev = 1; e_vic = m_sa[ms];
                    m_sa[ms] = app;
                end else e_dec = 2;
            end
        end
    endtask

    task automatic arrive(input int app, input bit inject, input string tag);
        int e_dec, e_slot, e_ev, e_vic, e_lat, lat;
        model_step(app, e_dec, e_slot, e_ev, e_vic, e_lat);
        @(posedge clk); #1;
        req_valid = 1'b1; req_app = AW'(app);
        @(posedge clk); #1;
        req_valid = inject; req_app = AW'((app + 1) % NA);
        lat = 0;
        while (lat < 40) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
            lat++;
            if (done) break;
        end
        check(done == 1'b1, {tag, " R8"}, "done pulse", done, 1);
        check(lat == e_lat, {tag, " R8"}, "latency", lat, e_lat);
        check(decision == 2'(e_dec), tag, "decision", decision, e_dec);
        check(evict == e_ev, tag, "evict", evict, e_ev);
        if (e_dec == 1) check(slot == SW'(e_slot), tag, "slot", slot, e_slot);
        if (e_ev == 1) check(victim_app == AW'(e_vic), tag, "victim", victim_app, e_vic);
        g_dec = decision; g_lat = lat; g_vic = victim_app; g_slot = slot;
        if (inject) begin
            repeat (4) begin
                @(posedge clk); #1;
                check(done == 1'b0, "R9", "extra decision", done, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        knobs(200, 256);
        do_reset();
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // R1 R2 R3 R6: short trace, only the second a0 arrival loads
        cfg(0, 200, 10); cfg(1, 100, 20); cfg(2, 50, 25);
        arrive(0, 0, "R2 R3");
        arrive(0, 0, "R1 R4");
        check(g_dec == 1 && g_slot == 0, "R1", "first load into slot 0", g_dec, 1);
        arrive(2, 0, "R3"); arrive(1, 0, "R3"); arrive(1, 1, "R9");
        arrive(0, 0, "R6");
        check(g_dec == 0, "R6", "resident report", g_dec, 0);
        arrive(2, 0, "R3");

        // R5: refusal at 225 vs victim 320, then eviction
        do_reset(); knobs(200, 256);
        cfg(0, 200, 10); cfg(1, 100, 20); cfg(2, 50, 25);
        arrive(0, 0, "R4"); arrive(0, 0, "R4");
        for (int k = 0; k < 4; k++) arrive(1, 0, "R4 R6");
        for (int k = 0; k < 9; k++) arrive(2, 0, "R3 R5");
        check(g_dec == 2 && g_lat == 2 + NS, "R5", "refused replacement", g_dec, 2);
        for (int k = 0; k < 12; k++) arrive(2, 0, "R5");
        check(g_dec == 1 && g_vic == 1, "R5", "evicts lowest resident", g_vic, 1);

        // R7: half fade changes the victim choice
        do_reset(); knobs(50, 128);
        cfg(0, 110, 10); cfg(1, 70, 10); cfg(2, 100, 10);
        arrive(0, 0, "R7"); arrive(1, 0, "R7"); arrive(2, 0, "R7 R5");
        check(g_dec == 1 && g_vic == 0, "R7", "faded victim", g_vic, 0);

        // R3 R2: equality and negative saving
        do_reset(); knobs(190, 256);
        cfg(0, 200, 10); cfg(1, 10, 50);
        arrive(0, 0, "R3");
        check(g_dec == 2, "R3", "equal to load time", g_dec, 2);
        arrive(0, 0, "R3");
        knobs(0, 256);
        arrive(1, 0, "R2");
        check(g_dec == 2, "R2", "zero saving", g_dec, 2);

        // R5 tie: equal scores pick slot 0
        do_reset(); knobs(0, 256);
        cfg(0, 20, 10); cfg(1, 30, 20); cfg(2, 110, 10);
        arrive(0, 0, "R4"); arrive(1, 0, "R4"); arrive(2, 0, "R5");
        check(g_slot == 0 && g_vic == 0, "R5", "tie to lower slot", g_slot, 0);

        // Constrained random
        do_reset();
        for (int round = 0; round < 5; round++) begin
            knobs($urandom_range(400, 0), $urandom_range(300, 150));
            for (int a = 0; a < NA; a++)
                if (round == 0 || $urandom_range(1, 0) == 1)
                    cfg(a, $urandom_range(300, 0), $urandom_range(300, 0));
            for (int n = 0; n < 80; n++)
                arrive($urandom_range(NA - 1, 0), (n % 7) == 3, "R2 R3 R4 R5 R6 R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule